// File: doc/BRIEF.md
# FIFO Read Controller with Mark and Replay

This block steers the read side of a single-clock FIFO and lets the consumer replay a stretch of data. Whenever the mark input is high on a clock edge, the address being read in that cycle is stored as a bookmark. A later active-low replay request rewinds the read pointer to the bookmark, so everything written since that point is delivered again. The write pointer and the full flag live in the same block. While a bookmark is held, the full flag protects the bookmarked data instead of only the unread data.

Two resets bring the pointers back to address zero and drop the bookmark. The asynchronous master reset is meant for power-up. The synchronous partial reset is meant for flushing the queue in the middle of operation. The storage array is outside the block: it is addressed with `wr_addr` and `rd_addr` and qualified by `wr_ok` and `rd_ok`.

The read sequencer has two states. RD_RUN is normal streaming. RD_RELOAD is the one-cycle settling state that follows a rewind. Transitions: RD_RUN→RD_RELOAD when a replay is accepted; RD_RELOAD→RD_RELOAD when another replay is accepted; RD_RELOAD→RD_RUN otherwise; RD_RUN→RD_RUN otherwise; any state→RD_RUN on either reset.

Top module: `fifo_mark_rewind`

## Requirements
- R1: While `mrst_n` is low (asynchronous), `rd_addr` and `wr_addr` are 0, `empty` is 1, `full` is 0 and no bookmark is held.
- R2: A write is taken (`wr_ok`=1) when `wr_en`=1 and `full`=0, and `wr_addr` then advances by one modulo DEPTH. With no bookmark, `full` rises after DEPTH unread writes. While `full`=1, `wr_addr` does not move.
- R3: A read is taken (`rd_ok`=1, in the same cycle) when `rd_en`=1, `empty`=0, the sequencer is in RD_RUN and no replay is accepted in that cycle. `rd_addr` then advances by one. `rd_ok` is never 1 while `empty`=1.
- R4: When `mark`=1 on an edge, the `rd_addr` value of that cycle becomes the bookmark, including in a cycle where a read is also taken.
- R5: When `rt_n`=0 on an edge while a bookmark is held, `rd_addr` equals the bookmark after that edge.
- R6: In a cycle where a replay is accepted, `rd_ok` is 0 even if `rd_en`=1 and data is present.
- R7: In the cycle that follows an accepted replay (RD_RELOAD), `empty` reads 1. From the next edge on, `empty` again reflects the comparison of the reloaded read pointer with the write pointer.
- R8: `rt_n`=0 with no bookmark held has no effect: a read requested in that cycle is taken normally.
- R9: `prst_n` low on an edge (synchronous) sets both addresses to 0, empties the FIFO and drops the bookmark, so a later replay request is ignored.
- R10: While a bookmark is held, `full` is measured from the bookmark: it is 1 once DEPTH entries have been written since the bookmarked address, even if reads have moved past it.
- R11: A new `mark` replaces the previous bookmark, and a replay then returns to the newer address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| mrst_n | input | 1 | Master reset, asynchronous, active low |
| prst_n | input | 1 | Partial reset, synchronous, active low |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| mark | input | 1 | Record the current read address as bookmark |
| rt_n | input | 1 | Replay request, active low |
| wr_addr | output | ADDR_W | Storage address for the next write |
| rd_addr | output | ADDR_W | Storage address being read |
| wr_ok | output | 1 | Write accepted this cycle |
| rd_ok | output | 1 | Read accepted this cycle |
| empty | output | 1 | No readable data, or settling after a rewind |
| full | output | 1 | No room left to write |

## Verification
A wrong bookmark stays invisible until a replay is requested. At that point `rd_addr` lands on the wrong address one edge later, so each test replays and compares the landing address. A sequencer stuck in RD_RELOAD shows at once as `empty` staying high with data present. A full flag computed from the read pointer instead of the bookmark lets `wr_addr` move past the bookmark on the very next write, so the tests fill to the bookmark boundary and push one more write.

// File: rtl/fifo_mark_rewind_pkg.sv
package fifo_mark_rewind_pkg;

    // Read sequencer states
    typedef enum logic [0:0] {
        RD_RUN    = 1'b0,   // normal streaming
        RD_RELOAD = 1'b1    // one settling cycle after a rewind
    } rd_state_e;

endpackage

// File: rtl/fifo_wr_side.sv
module fifo_wr_side #(
    parameter int ADDR_W = 4,
    localparam int PTR_W = ADDR_W + 1
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             prst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] base_ptr,   // oldest location that must be kept
    output logic [PTR_W-1:0] wptr,
    output logic             full,
    output logic             wr_ok
);

    logic [PTR_W-1:0] occupancy;

    // The pointers never drift more than DEPTH apart, so the top bit of the
    // difference is set exactly when the queue holds DEPTH entries.
    always_comb begin
        occupancy = wptr - base_ptr;
        full      = occupancy[ADDR_W];
        wr_ok     = wr_en && !full;
    end

    always_ff @(posedge clk or negedge mrst_n) begin
        if (!mrst_n) begin
            wptr <= '0;
        end else if (!prst_n) begin
            wptr <= '0;
        end else if (wr_ok) begin
            wptr <= wptr + 1'b1;
        end
    end

endmodule

// File: rtl/fifo_mark_store.sv
module fifo_mark_store #(
    parameter int ADDR_W = 4,
    localparam int PTR_W = ADDR_W + 1
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             prst_n,
    input  logic             mark,
    input  logic [PTR_W-1:0] rptr,
    output logic [PTR_W-1:0] mark_ptr,
    output logic             mark_vld
);

    always_ff @(posedge clk or negedge mrst_n) begin
        if (!mrst_n) begin
            mark_ptr <= '0;
            mark_vld <= 1'b0;
        end else if (!prst_n) begin
            mark_ptr <= '0;
            mark_vld <= 1'b0;
        end else if (mark) begin
            // the address being read in this cycle, before any advance
            mark_ptr <= rptr;
            mark_vld <= 1'b1;
        end
    end

endmodule

// File: rtl/fifo_rd_seq.sv
module fifo_rd_seq
    import fifo_mark_rewind_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int PTR_W = ADDR_W + 1
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             prst_n,
    input  logic             rd_en,
    input  logic             rt_n,
    input  logic             mark_vld,
    input  logic [PTR_W-1:0] mark_ptr,
    input  logic [PTR_W-1:0] wptr,
    output logic [PTR_W-1:0] rptr,
    output logic             empty,
    output logic             rd_ok
);

    rd_state_e state_q;
    rd_state_e state_d;
    logic      rewind;
    logic      ptr_equal;

    always_comb begin
        rewind    = !rt_n && mark_vld;
        ptr_equal = (rptr == wptr);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_RUN:    state_d = rewind ? RD_RELOAD : RD_RUN;
            RD_RELOAD: state_d = rewind ? RD_RELOAD : RD_RUN;
            default:   state_d = RD_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge mrst_n) begin
        if (!mrst_n) begin
            state_q <= RD_RUN;
        end else if (!prst_n) begin
            state_q <= RD_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        empty = 1'b1;
        rd_ok = 1'b0;
        unique case (state_q)
            RD_RUN: begin
                empty = ptr_equal;
                rd_ok = rd_en && !ptr_equal && !rewind;
            end
            RD_RELOAD: begin
                empty = 1'b1;
                rd_ok = 1'b0;
            end
            default: begin
                empty = 1'b1;
                rd_ok = 1'b0;
            end
        endcase
    end

    // Read pointer: a rewind wins over a read in the same cycle
    always_ff @(posedge clk or negedge mrst_n) begin
        if (!mrst_n) begin
            rptr <= '0;
        end else if (!prst_n) begin
            rptr <= '0;
        end else if (rewind) begin
            rptr <= mark_ptr;
        end else if (rd_ok) begin
            rptr <= rptr + 1'b1;
        end
    end

endmodule

// File: rtl/fifo_mark_rewind.sv
module fifo_mark_rewind #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              mrst_n,
    input  logic              prst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              mark,
    input  logic              rt_n,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_ok,
    output logic              rd_ok,
    output logic              empty,
    output logic              full
);

    localparam int PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0]  wptr;
    logic [PTR_W-1:0]  rptr;
    logic [PTR_W-1:0]  mark_ptr;
    logic [PTR_W-1:0]  base_ptr;
    logic              mark_vld;
    logic [ADDR_W-1:0] mark_addr;

    // With a bookmark held, the writer must stop short of it
    always_comb begin
        base_ptr  = mark_vld ? mark_ptr : rptr;
        mark_addr = mark_ptr[ADDR_W-1:0];
        wr_addr   = wptr[ADDR_W-1:0];
        rd_addr   = rptr[ADDR_W-1:0];
    end

    fifo_wr_side #(.ADDR_W(ADDR_W)) u_wr (
        .clk      (clk),
        .mrst_n   (mrst_n),
        .prst_n   (prst_n),
        .wr_en    (wr_en),
        .base_ptr (base_ptr),
        .wptr     (wptr),
        .full     (full),
        .wr_ok    (wr_ok)
    );

    fifo_mark_store #(.ADDR_W(ADDR_W)) u_mark (
        .clk      (clk),
        .mrst_n   (mrst_n),
        .prst_n   (prst_n),
        .mark     (mark),
        .rptr     (rptr),
        .mark_ptr (mark_ptr),
        .mark_vld (mark_vld)
    );

    fifo_rd_seq #(.ADDR_W(ADDR_W)) u_rd (
        .clk      (clk),
        .mrst_n   (mrst_n),
        .prst_n   (prst_n),
        .rd_en    (rd_en),
        .rt_n     (rt_n),
        .mark_vld (mark_vld),
        .mark_ptr (mark_ptr),
        .wptr     (wptr),
        .rptr     (rptr),
        .empty    (empty),
        .rd_ok    (rd_ok)
    );

endmodule

// File: rtl/fifo_mark_rewind_chk.sv
module fifo_mark_rewind_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              mrst_n,
    input logic              prst_n,
    input logic              rt_n,
    input logic              rd_ok,
    input logic              empty,
    input logic              full,
    input logic              mark_vld,
    input logic [ADDR_W-1:0] mark_addr,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [ADDR_W-1:0] wr_addr
);

    // R3: no read is granted while empty
    a_r3_no_read_empty: assert property (@(posedge clk) disable iff (!mrst_n)
        empty |-> !rd_ok);

    // R3: a granted read advances the read address by one
    a_r3_read_step: assert property (@(posedge clk) disable iff (!mrst_n)
        (rd_ok && prst_n) |=> rd_addr == ADDR_W'($past(rd_addr) + 1'b1));

    // R2: a full queue keeps the write address still
    a_r2_hold_full: assert property (@(posedge clk) disable iff (!mrst_n)
        (full && prst_n) |=> $stable(wr_addr));

    // R5: an accepted replay lands on the bookmark
    a_r5_rewind_addr: assert property (@(posedge clk) disable iff (!mrst_n)
        (prst_n && !rt_n && mark_vld) |=> rd_addr == $past(mark_addr));

    // R6: no read in the replay cycle
    a_r6_rewind_blocks: assert property (@(posedge clk) disable iff (!mrst_n)
        (!rt_n && mark_vld) |-> !rd_ok);

    // R7: settling cycle reports empty
    a_r7_settle_empty: assert property (@(posedge clk) disable iff (!mrst_n)
        (prst_n && !rt_n && mark_vld) |=> empty);

    // R9: partial reset clears pointers and bookmark
    a_r9_partial_reset: assert property (@(posedge clk) disable iff (!mrst_n)
        !prst_n |=> (rd_addr == '0 && wr_addr == '0 && !mark_vld && empty));

endmodule

bind fifo_mark_rewind fifo_mark_rewind_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .mrst_n    (mrst_n),
    .prst_n    (prst_n),
    .rt_n      (rt_n),
    .rd_ok     (rd_ok),
    .empty     (empty),
    .full      (full),
    .mark_vld  (mark_vld),
    .mark_addr (mark_addr),
    .rd_addr   (rd_addr),
    .wr_addr   (wr_addr)
);

// File: tb/tb_fifo_mark_rewind.sv
module tb_fifo_mark_rewind;

    localparam int ADDR_W = 4;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              mrst_n = 1'b0;
    logic              prst_n = 1'b1;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic              mark = 1'b0;
    logic              rt_n = 1'b1;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic              wr_ok;
    logic              rd_ok;
    logic              empty;
    logic              full;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    fifo_mark_rewind #(.ADDR_W(ADDR_W)) dut (
        .clk     (clk),
        .mrst_n  (mrst_n),
        .prst_n  (prst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .mark    (mark),
        .rt_n    (rt_n),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr),
        .wr_ok   (wr_ok),
        .rd_ok   (rd_ok),
        .empty   (empty),
        .full    (full)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // advance one edge; inputs change and outputs are sampled 2 ns after it
    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic do_writes(input int n);
        wr_en = 1'b1;
        repeat (n) cyc();
        wr_en = 1'b0;
    endtask

    task automatic do_reads(input int n);
        rd_en = 1'b1;
        repeat (n) cyc();
        rd_en = 1'b0;
    endtask

    task automatic do_mark();
        mark = 1'b1;
        cyc();
        mark = 1'b0;
    endtask

    task automatic partial_reset();
        prst_n = 1'b0;
        cyc();
        prst_n = 1'b1;
    endtask

    task automatic t_reset();
        #1;
        check("R1 rd_addr", rd_addr, 0);
        check("R1 wr_addr", wr_addr, 0);
        check("R1 empty", empty, 1);
        check("R1 full", full, 0);
        mrst_n = 1'b1;
        cyc();
    endtask

    task automatic t_stream();
        do_writes(3);
        check("R2 wr_addr after 3", wr_addr, 3);
        check("R2 not empty", empty, 0);
        rd_en = 1'b1;
        #1;
        check("R3 rd_ok granted", rd_ok, 1);
        cyc();
        check("R3 rd_addr step", rd_addr, 1);
        cyc(); cyc();
        #1;
        check("R3 empty after drain", empty, 1);
        check("R3 no read when empty", rd_ok, 0);
        cyc();
        rd_en = 1'b0;
        check("R3 rd_addr holds empty", rd_addr, 3);
    endtask

    task automatic t_fill();
        partial_reset();
        do_writes(DEPTH);
        check("R2 full after DEPTH", full, 1);
        check("R2 wr_addr wrapped", wr_addr, 0);
        wr_en = 1'b1;
        #1;
        check("R2 wr_ok low when full", wr_ok, 0);
        cyc();
        wr_en = 1'b0;
        check("R2 wr_addr held", wr_addr, 0);
    endtask

    task automatic t_replay();
        partial_reset();
        do_writes(6);
        do_reads(2);
        // bookmark and read on the same edge: bookmark is address 2
        rd_en = 1'b1; mark = 1'b1;
        cyc();
        mark = 1'b0;
        check("R4 read with mark", rd_addr, 3);
        cyc(); cyc();
        check("R4 before replay", rd_addr, 5);
        rt_n = 1'b0;
        #1;
        check("R6 read blocked", rd_ok, 0);
        cyc();
        rt_n = 1'b1; rd_en = 1'b0;
        check("R5 landed on mark", rd_addr, 2);
        check("R7 settle empty", empty, 1);
        cyc();
        check("R7 empty recomputed", empty, 0);
        check("R7 rd_addr stable", rd_addr, 2);
    endtask

    task automatic t_no_mark();
        partial_reset();
        do_writes(3);
        rt_n = 1'b0; rd_en = 1'b1;
        #1;
        check("R8 read granted", rd_ok, 1);
        cyc();
        rt_n = 1'b1; rd_en = 1'b0;
        check("R8 rd_addr advanced", rd_addr, 1);
        check("R8 not empty", empty, 0);
    endtask

    task automatic t_partial();
        partial_reset();
        do_writes(4);
        do_mark();
        do_reads(2);
        partial_reset();
        check("R9 rd_addr", rd_addr, 0);
        check("R9 wr_addr", wr_addr, 0);
        check("R9 empty", empty, 1);
        do_writes(2);
        do_reads(1);
        rt_n = 1'b0; rd_en = 1'b1;
        #1;
        check("R9 replay ignored rd_ok", rd_ok, 1);
        cyc();
        rt_n = 1'b1; rd_en = 1'b0;
        check("R9 replay ignored rd_addr", rd_addr, 2);
    endtask

    task automatic t_mark_full();
        partial_reset();
        do_writes(4);
        do_mark();
        do_reads(4);
        check("R10 drained", empty, 1);
        do_writes(DEPTH - 4);
        check("R10 full from mark", full, 1);
        wr_en = 1'b1;
        cyc();
        wr_en = 1'b0;
        check("R10 write held", wr_addr, 0);
        rt_n = 1'b0;
        cyc();
        rt_n = 1'b1;
        check("R10 rewind to 0", rd_addr, 0);
        cyc();
        check("R10 replay data present", empty, 0);
    endtask

    task automatic t_remark();
        partial_reset();
        do_writes(5);
        do_mark();
        do_reads(2);
        do_mark();
        do_reads(1);
        rt_n = 1'b0;
        cyc();
        rt_n = 1'b1;
        check("R11 newer bookmark", rd_addr, 2);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_stream();
        t_fill();
        t_replay();
        t_no_mark();
        t_partial();
        t_mark_full();
        t_remark();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule